// File: doc/BRIEF.md
# Zero-Page Bit-Test Branch Sequencer

This block is the micro-sequencer that an 8-bit CPU core hands control to when it decodes one of the bit-test-and-branch opcodes, which are the sixteen opcodes ending in hex F. The core supplies the opcode and the address of the opcode byte, then pulses `start`. The sequencer then owns a simple synchronous read bus for five consecutive cycles. A read issued in a cycle returns its data in that same cycle.

The five reads are the opcode byte, the zero-page address operand, the zero-page byte itself, the signed branch offset, and one dummy read. Opcode bits 6:4 pick the bit of the zero-page byte to test. Opcode bit 7 picks the polarity. The dummy read goes to a half-updated address: the low byte of the next-instruction address with the offset already added, but the high byte not yet carried. In the clock cycle after the fifth read, the block raises `done` for one cycle and presents the new program counter. A taken branch costs no extra cycle.

Top module: `zp_bit_branch_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `bus_rd` and `done` are 0 and `pc_out` is 0x0000. A reset asserted in the middle of an instruction abandons that instruction.
- R2: When `start` is high in an idle cycle, the next five cycles each have `bus_rd`=1. Their addresses are P, P+1, (zero-page address), P+2 and (dummy address), where P is the value of `pc_in` when `start` was accepted.
- R3: The tested bit of the zero-page byte is the bit whose index is opcode[6:4].
- R4: If opcode[7]=1, the branch is taken when the tested bit is 1. If opcode[7]=0, the branch is taken when the tested bit is 0.
- R5: The dummy read address has the high byte of N=P+3. Its low byte is (N[7:0] + offset) mod 256. This holds whether or not the branch is taken.
- R6: For a taken branch, `pc_out` = N + sign-extended offset, as a full 16-bit sum with the carry into the high byte.
- R7: For a branch that is not taken, `pc_out` = N. The dummy read still takes place.
- R8: `done` is high for exactly one cycle, in the cycle after the fifth read. In that cycle `bus_rd` is 0 and `pc_out` holds the result. Taken and not-taken branches both take five read cycles.
- R9: A `start` pulse that arrives while an instruction is in progress is ignored. The bus trace and the result are unchanged.
- R10: The zero-page read address is {0x00, operand byte}, where the operand byte is the data returned by the second read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| opcode | input | 8 | Opcode of the instruction being started |
| pc_in | input | 16 | Address of the opcode byte |
| bus_addr | output | 16 | Read address |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid in the same cycle as the strobe |
| pc_out | output | 16 | Updated program counter, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses both polarities on the same byte, so that a swapped polarity shows up as a wrong final PC. It then sweeps all eight bit indices against a byte with mixed bits, which exposes a wrong index field. Offsets with a carry out of the low byte, both forward and backward, separate the half-updated dummy address from the fully carried result. A stray `start` in mid-instruction and a reset in mid-instruction show whether the sequencer can be disturbed while busy.

// File: rtl/zbb_pkg.sv
package zbb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_OPC   = 3'd1,
      ST_ZPA   = 3'd2,
      ST_ZPD   = 3'd3,
      ST_OFS   = 3'd4,
      ST_DUMMY = 3'd5
   } zbb_state_e;
endpackage

// File: rtl/zbb_bit_cond.sv
module zbb_bit_cond #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [IDX_W-1:0]  idx,
   input  logic              sense,
   output logic              taken
);
   logic [DATA_W-1:0] hit;
   logic              sel_bit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_hit
      assign hit[i] = (idx == IDX_W'(i)) & data[i];
   end

   assign sel_bit = |hit;
   assign taken   = sense ? sel_bit : ~sel_bit;
endmodule

// File: rtl/zbb_pc_adder.sv
module zbb_pc_adder #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] off,
   output logic [ADDR_W-1:0] half_addr,
   output logic [ADDR_W-1:0] full_sum
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] off_sx;
   logic [DATA_W-1:0] lo_sum;

   assign off_sx    = {{HI_W{off[DATA_W-1]}}, off};
   assign lo_sum    = pc[DATA_W-1:0] + off;
   assign half_addr = {pc[ADDR_W-1:DATA_W], lo_sum};
   assign full_sum  = pc + off_sx;
endmodule

// File: rtl/zp_bit_branch_seq.sv
module zp_bit_branch_seq #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int IDX_LSB = 4,
   parameter logic [ADDR_W-DATA_W-1:0] ZP_PAGE = '0,
   parameter bit OPCODE_FROM_BUS = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] opcode,
   input  logic [ADDR_W-1:0] pc_in,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] pc_out,
   output logic              done
);
   import zbb_pkg::*;

   localparam int IDX_W = $clog2(DATA_W);
   localparam int SENSE_BIT = DATA_W - 1;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   if (ADDR_W <= DATA_W) begin : g_chk_w
      $error("ADDR_W must exceed DATA_W");
   end
   if (IDX_LSB + IDX_W > SENSE_BIT) begin : g_chk_idx
      $error("index field overlaps the sense bit");
   end

   zbb_state_e        state;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_out_q;
   logic [DATA_W-1:0] zp_q;
   logic [DATA_W-1:0] off_q;
   logic [IDX_W-1:0]  idx_q;
   logic              sense_q;
   logic              taken_q;
   logic              done_q;

   logic              opc_cap;
   logic [DATA_W-1:0] opc_src;
   logic              cond_taken;
   logic [ADDR_W-1:0] half_addr;
   logic [ADDR_W-1:0] full_sum;

   if (OPCODE_FROM_BUS) begin : g_opc_bus
      logic unused_opc;
      assign unused_opc = ^opcode;
      assign opc_cap = (state == ST_OPC);
      assign opc_src = bus_rdata;
   end else begin : g_opc_port
      assign opc_cap = (state == ST_IDLE) && start;
      assign opc_src = opcode;
   end

   zbb_bit_cond #(.DATA_W(DATA_W)) u_cond (
      .data  (bus_rdata),
      .idx   (idx_q),
      .sense (sense_q),
      .taken (cond_taken)
   );

   zbb_pc_adder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_add (
      .pc        (pc_q),
      .off       (off_q),
      .half_addr (half_addr),
      .full_sum  (full_sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         pc_q     <= '0;
         pc_out_q <= '0;
         zp_q     <= '0;
         off_q    <= '0;
         idx_q    <= '0;
         sense_q  <= 1'b0;
         taken_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (opc_cap) begin
            idx_q   <= opc_src[IDX_LSB +: IDX_W];
            sense_q <= opc_src[SENSE_BIT];
         end
         case (state)
            ST_IDLE: if (start) begin
               pc_q  <= pc_in;
               state <= ST_OPC;
            end
            ST_OPC: begin
               pc_q  <= pc_q + ONE;
               state <= ST_ZPA;
            end
            ST_ZPA: begin
               zp_q  <= bus_rdata;
               pc_q  <= pc_q + ONE;
               state <= ST_ZPD;
            end
            ST_ZPD: begin
               taken_q <= cond_taken;
               state   <= ST_OFS;
            end
            ST_OFS: begin
               off_q <= bus_rdata;
               pc_q  <= pc_q + ONE;
               state <= ST_DUMMY;
            end
            ST_DUMMY: begin
               pc_out_q <= taken_q ? full_sum : pc_q;
               done_q   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_OPC, ST_ZPA, ST_OFS: bus_addr = pc_q;
         ST_ZPD:                 bus_addr = {ZP_PAGE, zp_q};
         ST_DUMMY:               bus_addr = half_addr;
         default:                bus_addr = '0;
      endcase
   end

   assign bus_rd = (state != ST_IDLE);
   assign pc_out = pc_out_q;
   assign done   = done_q;

   assert_fetch_at_pc_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && start) |=> (bus_rd && bus_addr == $past(pc_in)));

   assert_zp_page_R10: assert property (@(posedge clk) disable iff (rst)
      (state == ST_ZPD) |-> (bus_addr == {ZP_PAGE, $past(bus_rdata)}));

   assert_dummy_half_R5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DUMMY) |-> (bus_addr[DATA_W-1:0] == full_sum[DATA_W-1:0]
                               && bus_addr[ADDR_W-1:DATA_W] == pc_q[ADDR_W-1:DATA_W]));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_bus_idle_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> !bus_rd);

   assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && state != ST_DUMMY) |=> bus_rd);

   assert_not_taken_pc_R7: assert property (@(posedge clk) disable iff (rst)
      (done && !taken_q) |-> (pc_out == pc_q));
endmodule

// File: tb/sim_zp_bit_branch_seq.sv
`timescale 1ns/1ps
module sim_zp_bit_branch_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [15:0] pc_in = 16'h0000;
   logic [15:0] bus_addr;
   logic        bus_rd;
   logic [7:0]  bus_rdata;
   logic [15:0] pc_out;
   logic        done;

   int checks = 0;
   int errors = 0;

   logic [15:0] s_pc = 16'h0000;
   logic [7:0]  s_zp = 8'h00;
   logic [7:0]  s_data = 8'h00;
   logic [7:0]  s_off = 8'h00;

   always #4 clk = ~clk;

   zp_bit_branch_seq u0 (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .opcode    (opcode),
      .pc_in     (pc_in),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pc_out    (pc_out),
      .done      (done)
   );

   always_comb begin
      if (bus_addr == s_pc + 16'd1)         bus_rdata = s_zp;
      else if (bus_addr == {8'h00, s_zp})   bus_rdata = s_data;
      else if (bus_addr == s_pc + 16'd2)    bus_rdata = s_off;
      else                                  bus_rdata = bus_addr[7:0] ^ bus_addr[15:8] ^ 8'hA5;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_instr(input logic [7:0] opc, input logic [15:0] p, input logic [7:0] z,
                            input logic [7:0] d, input logic [7:0] o, input bit poke);
      logic [15:0] n, dummy, fin;
      logic [15:0] ea [5];
      logic        tbit, tk;
      n     = p + 16'd3;
      dummy = {n[15:8], n[7:0] + o};
      tbit  = d[opc[6:4]];
      tk    = opc[7] ? tbit : !tbit;
      fin   = tk ? n + {{8{o[7]}}, o} : n;
      ea[0] = p; ea[1] = p + 16'd1; ea[2] = {8'h00, z}; ea[3] = p + 16'd2; ea[4] = dummy;
      s_pc = p; s_zp = z; s_data = d; s_off = o;
      @(negedge clk);
      start = 1'b1; opcode = opc; pc_in = p;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke && k == 1) begin
            start = 1'b1; opcode = ~opc; pc_in = p ^ 16'h1234;
         end
         check(bus_rd == 1'b1, "R2 read strobe", 32'(bus_rd), 32'd1);
         if (k == 2)
            check(bus_addr == ea[k], "R10 zero-page address", 32'(bus_addr), 32'(ea[k]));
         else if (k == 4)
            check(bus_addr == ea[k], "R5 dummy address", 32'(bus_addr), 32'(ea[k]));
         else
            check(bus_addr == ea[k], poke ? "R9 R2 trace" : "R2 trace", 32'(bus_addr), 32'(ea[k]));
      end
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R8 done pulse", 32'(done), 32'd1);
      check(bus_rd == 1'b0, "R8 bus idle at done", 32'(bus_rd), 32'd0);
      check(pc_out == fin, tk ? "R6 taken pc (R3,R4)" : "R7 not-taken pc (R3,R4)",
            32'(pc_out), 32'(fin));
      @(negedge clk);
      check(done == 1'b0, "R8 single-cycle done", 32'(done), 32'd0);
      check(bus_rd == 1'b0, "R8 idle after done", 32'(bus_rd), 32'd0);
   endtask

   task automatic reset_midway();
      s_pc = 16'h5100; s_zp = 8'h21; s_data = 8'h00; s_off = 8'h04;
      @(negedge clk);
      start = 1'b1; opcode = 8'h0F; pc_in = 16'h5100;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(bus_rd == 1'b0, "R1 strobe in reset", 32'(bus_rd), 32'd0);
      check(pc_out == 16'h0000, "R1 pc_out in reset", 32'(pc_out), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check(bus_rd == 1'b0, "R1 instruction abandoned", 32'(bus_rd), 32'd0);
      check(done == 1'b0, "R1 no done after reset", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(bus_rd == 1'b0, "R1 strobe low", 32'(bus_rd), 32'd0);
      check(done == 1'b0, "R1 done low", 32'(done), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check(pc_out == 16'h0000, "R1 pc_out zero", 32'(pc_out), 32'd0);
      check(bus_rd == 1'b0, "R1 idle after reset", 32'(bus_rd), 32'd0);

      // clear-polarity, bit 0 clear: taken forward
      run_instr(8'h0F, 16'h1200, 8'h40, 8'hFE, 8'h10, 1'b0);
      // set-polarity on the same byte: not taken
      run_instr(8'h8F, 16'h1200, 8'h40, 8'hFE, 8'h10, 1'b0);
      // bit 7 set, backward offset across a page
      run_instr(8'hFF, 16'h34FE, 8'h77, 8'h80, 8'h80, 1'b0);
      // bit 7 clear, forward offset with low-byte wrap
      run_instr(8'h7F, 16'h20F0, 8'h05, 8'h7F, 8'h20, 1'b0);
      // sweep every bit index with both polarities
      for (int i = 0; i < 8; i++) begin
         run_instr({1'b0, 3'(i), 4'hF}, 16'h4000 + 16'(i * 16), 8'(8'h10 + i), 8'h5A, 8'(i * 3), 1'b0);
         run_instr({1'b1, 3'(i), 4'hF}, 16'h4080 + 16'(i * 16), 8'(8'h90 + i), 8'h5A, 8'(8'hF0 - i), 1'b0);
      end
      // stray start while busy
      run_instr(8'hAF, 16'h6610, 8'h33, 8'h04, 8'hFC, 1'b1);
      reset_midway();
      // clean instruction after the mid-run reset
      run_instr(8'h3F, 16'h7700, 8'h12, 8'hF7, 8'h7F, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule